// File: doc/BRIEF.md
# BCD preset load sequencer

This block arbitrates a shared four-bit BCD port between two uses: showing latched count digits during the normal display scan, and bringing preset digits in from switches, one digit per scan phase, for a four-decade counter and its compare register. It owns the digit scan phase. The phase steps on an external scan tick in normal operation and on an internal divided timebase while loading. The block also decodes the two three-level control inputs, load-counter and load-register, into port tri-state, display shut-down and load modes.

A load request that is seen high moves the scan to the most significant digit. It then runs a pass of four phases on the internal timebase. On the last cycle of each digit strobe, the switch value for that digit is written to the counter, the register or both. When a pass ends, the requests are sampled again. The pass repeats if any request is still high; otherwise the block hands the scan back to the external tick. While a pass is running, counting is inhibited if the counter is a target, and a status output tells downstream logic that the zero and equal flags are stale.

Top module: `bcd_preset_sequencer`

## Requirements
- R1: Each three-level control is a 2-bit code: 2'b00 means low, 2'b01 means high, and both 2'b10 and 2'b11 mean open.
- R2: In scan mode, a high code on either control starts a load pass. One cycle later flags_invalid is 1, and digit_sel strobes only D4 (bit 3; bit i strobes digit i+1). scan_tick pulses have no effect while a pass runs.
- R3: A pass writes one digit per phase, D4 first and then D3, D2, D1 (wr_idx 3, 2, 1, 0). Each phase lasts LOAD_DIV cycles. The write is taken on the last cycle of that digit's strobe, so writes are exactly LOAD_DIV cycles apart.
- R4: After the D1 write, the controls are sampled again. If either is high, a new pass starts at D4. Otherwise scan mode resumes.
- R5: A pass started by a high load-counter raises wr_cnt and count_inhibit. A pass started by a high load-register raises only wr_reg and leaves count_inhibit low. When both are high, each digit raises both strobes with one value.
- R6: While clr_n is low, every written value is 0.
- R7: With both controls open in scan mode, bcd_oe is 1 and bcd_out carries the latched digit of the strobed position (D4 = latch_digits[15:12]). Each scan_tick moves the strobe D4, D3, D2, D1 and back to D4.
- R8: A low load-counter forces bcd_oe to 0, while the display and the scan keep running.
- R9: A low load-register forces bcd_oe, disp_on and digit_sel to 0 and holds the phase at D4. Released, the strobe restarts at D4.
- R10: With low_true_in at 1, a written value is the inverse of bcd_in. bcd_out stays high-true.
- R11: flags_invalid is 1 exactly while a load pass is running, and falls in the cycle after the D1 write of the final pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| scan_tick | input | 1 | One-cycle pulse from the external scan source |
| lc_code | input | 2 | Load-counter three-level code |
| lr_code | input | 2 | Load-register three-level code |
| clr_n | input | 1 | Counter reset level; low zeroes captured digits |
| low_true_in | input | 1 | Strap: preset inputs are low-true |
| bcd_in | input | 4 | Preset digit from the switches |
| latch_digits | input | 16 | Latched count, D4 in the top nibble |
| bcd_out | output | 4 | Digit driven onto the port |
| bcd_oe | output | 1 | Port drive enable |
| digit_sel | output | 4 | One-hot digit strobe, bit 3 = D4 |
| disp_on | output | 1 | Segment drivers enabled |
| wr_cnt | output | 1 | Write strobe for one counter digit |
| wr_reg | output | 1 | Write strobe for one register digit |
| wr_idx | output | 2 | Digit index written (3 = D4) |
| wr_val | output | 4 | Digit value written |
| count_inhibit | output | 1 | Count input must be ignored |
| flags_invalid | output | 1 | Zero/equal flags are stale |

## Verification
The assertions assume that the control codes, clr_n and low_true_in change only between clock edges and hold steady for at least one cycle. They also assume that scan_tick is a single-cycle pulse. The bench drives every input on the falling edge and pulses scan_tick for one cycle at a time. It models the switches as a combinational response to digit_sel, so each preset value depends only on the strobe the block itself produces. It releases a load request in the middle of a pass, or right after a pass boundary, so the resample decision at the end of each pass is deterministic.

// File: rtl/bcd_seq_pkg.sv
package bcd_seq_pkg;

    // three-level control code; 2'b11 is read as open
    localparam logic [1:0] TL_LOW  = 2'b00;
    localparam logic [1:0] TL_HIGH = 2'b01;
    localparam logic [1:0] TL_OPEN = 2'b10;

    typedef enum logic {
        M_SCAN = 1'b0,
        M_LOAD = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/tri_level_decode.sv
module tri_level_decode
    import bcd_seq_pkg::*;
(
    input  logic [1:0] code,
    output logic       is_high,
    output logic       is_low,
    output logic       is_open
);
    always_comb begin
        is_high = (code == TL_HIGH);
        is_low  = (code == TL_LOW);
        is_open = code[1];
    end
endmodule

// File: rtl/scan_timebase.sv
module scan_timebase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/digit_scan_map.sv
module digit_scan_map #(
    parameter int DIGITS = 4,
    parameter int BCD_W  = 4,
    parameter int PW     = 2
) (
    input  logic [PW-1:0]           phase,
    input  logic [DIGITS*BCD_W-1:0] latch_digits,
    output logic [DIGITS-1:0]       strobe,
    output logic [BCD_W-1:0]        cur_digit
);
    logic [BCD_W-1:0] masked [DIGITS];

    // phase 0 is the most significant digit
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign strobe[g] = (phase == PW'(DIGITS - 1 - g));
        assign masked[g] = strobe[g] ? latch_digits[g*BCD_W +: BCD_W] : '0;
    end

    always_comb begin
        cur_digit = '0;
        for (int i = 0; i < DIGITS; i++) begin
            cur_digit = cur_digit | masked[i];
        end
    end
endmodule

// File: rtl/bcd_preset_sequencer.sv
module bcd_preset_sequencer
    import bcd_seq_pkg::*;
#(
    parameter int DIGITS   = 4,
    parameter int BCD_W    = 4,
    parameter int LOAD_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scan_tick,
    input  logic [1:0]                lc_code,
    input  logic [1:0]                lr_code,
    input  logic                      clr_n,
    input  logic                      low_true_in,
    input  logic [BCD_W-1:0]          bcd_in,
    input  logic [DIGITS*BCD_W-1:0]   latch_digits,
    output logic [BCD_W-1:0]          bcd_out,
    output logic                      bcd_oe,
    output logic [DIGITS-1:0]         digit_sel,
    output logic                      disp_on,
    output logic                      wr_cnt,
    output logic                      wr_reg,
    output logic [$clog2(DIGITS)-1:0] wr_idx,
    output logic [BCD_W-1:0]          wr_val,
    output logic                      count_inhibit,
    output logic                      flags_invalid
);
    localparam int PW = $clog2(DIGITS);
    localparam logic [PW-1:0] LAST_PH = PW'(DIGITS - 1);

    typedef struct packed {
        seq_mode_e       mode;
        logic [PW-1:0]   phase;
        logic            tgt_cnt;
        logic            tgt_reg;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic lc_hi, lc_lo, lc_open;
    logic lr_hi, lr_lo, lr_open;
    logic in_load, load_tick, wr_hit;
    logic [DIGITS-1:0] strobe;
    logic [BCD_W-1:0]  cur_digit;

    tri_level_decode i_lc_dec (
        .code    (lc_code),
        .is_high (lc_hi),
        .is_low  (lc_lo),
        .is_open (lc_open)
    );

    tri_level_decode i_lr_dec (
        .code    (lr_code),
        .is_high (lr_hi),
        .is_low  (lr_lo),
        .is_open (lr_open)
    );

    assign in_load = (st_q.mode == M_LOAD);

    scan_timebase #(.DIV(LOAD_DIV)) i_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_load),
        .tick  (load_tick)
    );

    digit_scan_map #(.DIGITS(DIGITS), .BCD_W(BCD_W), .PW(PW)) i_map (
        .phase        (st_q.phase),
        .latch_digits (latch_digits),
        .strobe       (strobe),
        .cur_digit    (cur_digit)
    );

    // next-state logic
    always_comb begin
        st_d   = st_q;
        wr_hit = 1'b0;
        unique case (st_q.mode)
            M_SCAN: begin
                if (lc_hi || lr_hi) begin
                    st_d.mode    = M_LOAD;
                    st_d.phase   = '0;
                    st_d.tgt_cnt = lc_hi;
                    st_d.tgt_reg = lr_hi;
                end else if (lr_lo) begin
                    st_d.phase = '0;
                end else if (scan_tick) begin
                    st_d.phase = (st_q.phase == LAST_PH) ? '0 : st_q.phase + 1'b1;
                end
            end
            M_LOAD: begin
                if (load_tick) begin
                    wr_hit = 1'b1;
                    if (st_q.phase == LAST_PH) begin
                        st_d.phase = '0;
                        if (lc_hi || lr_hi) begin
                            st_d.tgt_cnt = lc_hi;
                            st_d.tgt_reg = lr_hi;
                        end else begin
                            st_d.mode    = M_SCAN;
                            st_d.tgt_cnt = 1'b0;
                            st_d.tgt_reg = 1'b0;
                        end
                    end else begin
                        st_d.phase = st_q.phase + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: M_SCAN, phase: '0, tgt_cnt: 1'b0, tgt_reg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        digit_sel     = (in_load || !lr_lo) ? strobe : '0;
        disp_on       = !in_load && !lr_lo;
        bcd_oe        = !in_load && lc_open && lr_open;
        bcd_out       = bcd_oe ? cur_digit : '0;
        wr_cnt        = wr_hit && st_q.tgt_cnt;
        wr_reg        = wr_hit && st_q.tgt_reg;
        wr_idx        = LAST_PH - st_q.phase;
        wr_val        = !clr_n ? '0 : (low_true_in ? ~bcd_in : bcd_in);
        count_inhibit = in_load && st_q.tgt_cnt;
        flags_invalid = in_load;
    end
endmodule

// File: rtl/bcd_seq_checker.sv
module bcd_seq_checker #(
    parameter int DIGITS = 4,
    parameter int BCD_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                lc_code,
    input logic [1:0]                lr_code,
    input logic                      clr_n,
    input logic                      bcd_oe,
    input logic [DIGITS-1:0]         digit_sel,
    input logic                      disp_on,
    input logic                      wr_cnt,
    input logic                      wr_reg,
    input logic [$clog2(DIGITS)-1:0] wr_idx,
    input logic [BCD_W-1:0]          wr_val,
    input logic                      count_inhibit,
    input logic                      flags_invalid
);
    logic any_hi;
    assign any_hi = (lc_code == 2'b01) || (lr_code == 2'b01);

    a_r2_load_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_invalid && any_hi) |=> (flags_invalid && digit_sel[DIGITS-1]
                                        && $countones(digit_sel) == 1));

    a_r3_write_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt || wr_reg) |-> (flags_invalid && digit_sel[wr_idx]));

    a_r4_exit_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_invalid) |-> ($past(wr_cnt || wr_reg) && $past(wr_idx) == '0));

    a_r5_cnt_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |-> count_inhibit);

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_cnt || wr_reg) && !clr_n) |-> (wr_val == '0));

    a_r8_lc_low_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_code == 2'b00) |-> !bcd_oe);

    a_r9_display_off: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_code == 2'b00 && !flags_invalid) |-> (!bcd_oe && !disp_on && digit_sel == '0));

    a_r11_no_drive_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        flags_invalid |-> (!bcd_oe && !disp_on));
endmodule

bind bcd_preset_sequencer bcd_seq_checker #(.DIGITS(DIGITS), .BCD_W(BCD_W)) i_bcd_seq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .lc_code       (lc_code),
    .lr_code       (lr_code),
    .clr_n         (clr_n),
    .bcd_oe        (bcd_oe),
    .digit_sel     (digit_sel),
    .disp_on       (disp_on),
    .wr_cnt        (wr_cnt),
    .wr_reg        (wr_reg),
    .wr_idx        (wr_idx),
    .wr_val        (wr_val),
    .count_inhibit (count_inhibit),
    .flags_invalid (flags_invalid)
);

// File: tb/test_bcd_preset_sequencer.sv
module test_bcd_preset_sequencer;
    localparam int DIGITS   = 4;
    localparam int BCD_W    = 4;
    localparam int LOAD_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_tick;
    logic [1:0]  lc_code, lr_code;
    logic        clr_n, low_true_in;
    logic [3:0]  bcd_in;
    logic [15:0] latch_digits;
    logic [3:0]  bcd_out;
    logic        bcd_oe;
    logic [3:0]  digit_sel;
    logic        disp_on, wr_cnt, wr_reg;
    logic [1:0]  wr_idx;
    logic [3:0]  wr_val;
    logic        count_inhibit, flags_invalid;

    always #2.5 clk = ~clk;

    bcd_preset_sequencer #(.DIGITS(DIGITS), .BCD_W(BCD_W), .LOAD_DIV(LOAD_DIV)) i_bcd_preset_sequencer (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .lc_code(lc_code), .lr_code(lr_code),
        .clr_n(clr_n), .low_true_in(low_true_in), .bcd_in(bcd_in), .latch_digits(latch_digits),
        .bcd_out(bcd_out), .bcd_oe(bcd_oe), .digit_sel(digit_sel), .disp_on(disp_on),
        .wr_cnt(wr_cnt), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_val(wr_val),
        .count_inhibit(count_inhibit), .flags_invalid(flags_invalid)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // switch model: thumb[i] is digit i+1, seen only while its strobe is on
    logic [3:0] thumb [4];
    always_comb begin
        bcd_in = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (digit_sel[i]) bcd_in = thumb[i];
        end
        if (low_true_in) bcd_in = ~bcd_in;
    end

    // write log kept by the bench
    int         n_wr;
    int         n_cw, n_rw;
    int         wr_at [16];
    logic [1:0] wr_ix [16];
    logic [3:0] cnt_img [4];
    logic [3:0] reg_img [4];
    logic       inh_seen;

    always @(negedge clk) begin
        if (rst_n && (wr_cnt || wr_reg)) begin
            if (n_wr < 16) begin
                wr_at[n_wr] = cyc;
                wr_ix[n_wr] = wr_idx;
            end
            n_wr = n_wr + 1;
            if (wr_cnt) begin cnt_img[wr_idx] = wr_val; n_cw = n_cw + 1; end
            if (wr_reg) begin reg_img[wr_idx] = wr_val; n_rw = n_rw + 1; end
        end
        if (rst_n && count_inhibit) inh_seen = 1'b1;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cimg();
        return {cnt_img[3], cnt_img[2], cnt_img[1], cnt_img[0]};
    endfunction
    function automatic logic [15:0] rimg();
        return {reg_img[3], reg_img[2], reg_img[1], reg_img[0]};
    endfunction

    task automatic set_thumbs(input logic [15:0] v);
        thumb[3] = v[15:12]; thumb[2] = v[11:8]; thumb[1] = v[7:4]; thumb[0] = v[3:0];
    endtask

    task automatic pulse_tick();
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
    endtask

    task automatic clear_log();
        n_wr = 0; n_cw = 0; n_rw = 0; inh_seen = 1'b0;
    endtask

    task automatic wait_scan();
        for (int k = 0; k < 200; k++) begin
            if (!flags_invalid) break;
            @(negedge clk);
        end
    endtask

    // starts a pass, checks entry (R2), releases the requests mid-pass
    task automatic run_load(input logic [1:0] lc, input logic [1:0] lr);
        clear_log();
        @(negedge clk) begin lc_code = lc; lr_code = lr; end
        @(negedge clk);
        chk("R2 flags_invalid on entry", flags_invalid, 1);
        chk("R2 strobe at D4 on entry", digit_sel, 4'b1000);
        scan_tick = 1'b1;
        @(negedge clk) begin scan_tick = 1'b0; lc_code = 2'b10; lr_code = 2'b10; end
        chk("R2 scan_tick ignored in load", digit_sel, 4'b1000);
        wait_scan();
    endtask

    task automatic t_reset();
        chk("R7 reset strobe D4", digit_sel, 4'b1000);
        chk("R7 reset bcd_oe", bcd_oe, 1);
        chk("R7 reset disp_on", disp_on, 1);
        chk("R11 reset flags_invalid", flags_invalid, 0);
        chk("R7 reset bcd_out D4", bcd_out, 4'h1);
    endtask

    task automatic t_scan_out();
        lr_code = 2'b11; // R1: 11 reads as open
        @(negedge clk);
        chk("R1 code 11 open drives port", bcd_oe, 1);
        pulse_tick();
        chk("R7 strobe D3", digit_sel, 4'b0100);
        chk("R7 digit D3", bcd_out, 4'h2);
        pulse_tick();
        pulse_tick();
        chk("R7 digit D1", bcd_out, 4'h4);
        pulse_tick();
        chk("R7 wrap to D4", digit_sel, 4'b1000);
        lr_code = 2'b10;
    endtask

    task automatic t_lc_low();
        @(negedge clk) lc_code = 2'b00;
        @(negedge clk);
        chk("R8 lc low tri-states", bcd_oe, 0);
        chk("R8 lc low display on", disp_on, 1);
        pulse_tick();
        chk("R8 lc low scan runs", digit_sel, 4'b0100);
        @(negedge clk) lc_code = 2'b10;
        pulse_tick(); pulse_tick(); pulse_tick();
    endtask

    task automatic t_lr_low();
        pulse_tick();
        chk("R9 pre strobe D3", digit_sel, 4'b0100);
        @(negedge clk) lr_code = 2'b00;
        @(negedge clk);
        chk("R9 strobes off", digit_sel, 4'b0000);
        chk("R9 display off", disp_on, 0);
        chk("R9 port off", bcd_oe, 0);
        pulse_tick(); pulse_tick();
        @(negedge clk) lr_code = 2'b10;
        @(negedge clk);
        chk("R9 restart at D4", digit_sel, 4'b1000);
    endtask

    task automatic t_load_cnt();
        set_thumbs(16'h5678);
        reg_img[3] = 4'h0; reg_img[2] = 4'h0; reg_img[1] = 4'h0; reg_img[0] = 4'h0;
        run_load(2'b01, 2'b10);
        chk("R3 four writes", n_wr, 4);
        chk("R3 order", {wr_ix[0], wr_ix[1], wr_ix[2], wr_ix[3]}, 8'b11_10_01_00);
        chk("R3 spacing", wr_at[3] - wr_at[0], 3 * LOAD_DIV);
        chk("R3 spacing first", wr_at[1] - wr_at[0], LOAD_DIV);
        chk("R5 counter loaded", cimg(), 16'h5678);
        chk("R5 no register write", n_rw, 0);
        chk("R5 inhibit seen", inh_seen, 1);
        chk("R11 back in scan", flags_invalid, 0);
    endtask

    task automatic t_load_reg();
        set_thumbs(16'h9012);
        run_load(2'b10, 2'b01);
        chk("R5 register loaded", rimg(), 16'h9012);
        chk("R5 counter untouched", cimg(), 16'h5678);
        chk("R5 no inhibit on reg load", inh_seen, 0);
    endtask

    task automatic t_load_both();
        set_thumbs(16'h4321);
        run_load(2'b01, 2'b01);
        chk("R5 both counter", cimg(), 16'h4321);
        chk("R5 both register", rimg(), 16'h4321);
    endtask

    task automatic t_resample();
        set_thumbs(16'h1111);
        clear_log();
        @(negedge clk) lc_code = 2'b01;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (n_wr >= 4) break;
        end
        @(negedge clk);
        chk("R4 second pass runs", flags_invalid, 1);
        chk("R4 second pass at D4", digit_sel, 4'b1000);
        set_thumbs(16'h2468);
        lc_code = 2'b10;
        wait_scan();
        chk("R4 eight writes", n_wr, 8);
        chk("R4 second value", cimg(), 16'h2468);
    endtask

    task automatic t_clear();
        set_thumbs(16'h7777);
        clr_n = 1'b0;
        run_load(2'b10, 2'b01);
        clr_n = 1'b1;
        chk("R6 register zeroed", rimg(), 16'h0000);
    endtask

    task automatic t_low_true();
        low_true_in = 1'b1;
        set_thumbs(16'h3141);
        run_load(2'b01, 2'b10);
        chk("R10 low-true capture", cimg(), 16'h3141);
        @(negedge clk);
        chk("R10 output stays high-true", bcd_out, 4'h1);
        low_true_in = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; scan_tick = 1'b0; lc_code = 2'b10; lr_code = 2'b10;
        clr_n = 1'b1; low_true_in = 1'b0; latch_digits = 16'h1234;
        set_thumbs(16'h0000);
        clear_log();
        for (int i = 0; i < 4; i++) begin cnt_img[i] = 4'h0; reg_img[i] = 4'h0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan_out();
        t_lc_low();
        t_lr_low();
        t_load_cnt();
        t_load_reg();
        t_load_both();
        t_resample();
        t_clear();
        t_low_true();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule